// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block resolves the operand of a one-address accumulator instruction. A caller presents a 3-bit addressing mode, a 16-bit address/immediate field and a register index, together with a one-cycle start pulse. The block reads its own small register file and, where the mode calls for it, issues reads on a simple synchronous memory port. It returns the resolved operand and the effective address with a one-cycle done pulse.

The number of memory reads depends on the mode. Immediate and register modes need none. Direct, register-indirect and displacement modes need one read. Indirect mode needs two dependent reads: the first fetches a pointer, and the second uses that pointer as its address. A small state machine sequences these reads. The memory answers one cycle after each read strobe. A write port loads the register file.

Top module: `opnd_fetch_unit`

## Requirements
- R1: Mode code 0 (immediate) returns operand = the A field and eff_addr = 0, with no memory read.
- R2: Mode code 1 (direct) makes exactly one read at address A. It returns operand = the word read and eff_addr = A.
- R3: Mode code 2 (indirect) makes two reads. The first is at A. The second is at the pointer word returned by the first read, and it is issued only after that pointer has been captured. The block returns operand = the second word and eff_addr = the pointer.
- R4: Mode code 3 (register) returns operand = register R and eff_addr = 0, with no memory read.
- R5: Mode code 4 (register indirect) makes one read at the contents of register R. It returns the word read, with eff_addr = register R.
- R6: Mode code 5 (displacement) makes one read at (A + register R) mod 2^16 and returns that word, with eff_addr equal to that sum.
- R7: After reset, done and mem_rd are 0. Counting from the clock edge that accepts start, done is high for exactly one cycle after edge 1 (no read), edge 3 (one read) or edge 5 (two reads). operand, eff_addr and illegal are valid in that cycle.
- R8: Mode codes 6 and 7 give done with illegal = 1, operand = 0 and eff_addr = 0, with no memory read. illegal is 0 in every other cycle.
- R9: start is accepted only while the block is idle. A start that arrives during an operation has no effect on that operation's reads or results, and it starts nothing.
- R10: mem_rd is high for one cycle at a time, and mem_addr is valid while it is high. Read data is sampled on the clock edge one cycle after the strobe cycle.
- R11: When rf_we is high, rf_wdata is written to register rf_waddr on the clock edge. Later operations see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; taken only when idle |
| mode | input | 3 | Addressing mode code |
| fld_a | input | 16 | Address or immediate field |
| reg_idx | input | 3 | Register index R |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 3 | Register file write index |
| rf_wdata | input | 16 | Register file write data |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unused mode code, valid with done |
| operand | output | 16 | Resolved operand, valid with done |
| eff_addr | output | 16 | Effective address, valid with done |

## Verification
The assertions assume that the memory returns data exactly one cycle after the strobe. They also assume that an operation ends only with done, so the checker can infer which start pulses are accepted from start and done alone. The assertions do not check the register-file contents that a mode uses, so the stimulus writes the register file only while no operation is in flight. It never writes in the cycle in which start is given. Stray start pulses are issued in the middle of an indirect operation, and a new start is issued in the cycle right after done, to probe the edges of the idle window.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] AM_IMM  = 3'd0;
  localparam logic [MODE_W-1:0] AM_DIR  = 3'd1;
  localparam logic [MODE_W-1:0] AM_IND  = 3'd2;
  localparam logic [MODE_W-1:0] AM_REG  = 3'd3;
  localparam logic [MODE_W-1:0] AM_RIND = 3'd4;
  localparam logic [MODE_W-1:0] AM_DISP = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_RD,
    ST_CAP
  } opf_state_e;
endpackage

// File: rtl/opf_regfile.sv
module opf_regfile #(
  parameter int REG_CNT = 8,
  parameter int WORD_W  = 16,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] regs [REG_CNT];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rdata = regs[raddr];
endmodule

// File: rtl/opf_ea_calc.sv
module opf_ea_calc
  import opf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] rval_i,
  output logic [WORD_W-1:0] addr_o,
  output logic [WORD_W-1:0] opnd_o,
  output logic [1:0]        reads_o,
  output logic              bad_o
);
  always_comb begin
    addr_o  = a_i;
    opnd_o  = '0;
    reads_o = 2'd0;
    bad_o   = 1'b0;
    case (mode_i)
      AM_IMM:  opnd_o = a_i;
      AM_DIR:  reads_o = 2'd1;
      AM_IND:  reads_o = 2'd2;
      AM_REG:  opnd_o = rval_i;
      AM_RIND: begin
        addr_o  = rval_i;
        reads_o = 2'd1;
      end
      AM_DISP: begin
        addr_o  = a_i + rval_i;
        reads_o = 2'd1;
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] rval_i,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              illegal,
  output logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] eff_addr
);
  opf_state_e        state;
  logic [MODE_W-1:0] mode_q;
  logic [WORD_W-1:0] a_q;
  logic [WORD_W-1:0] rval_q;
  logic              ptr_phase;

  logic [WORD_W-1:0] ec_addr;
  logic [WORD_W-1:0] ec_opnd;
  logic [1:0]        ec_reads;
  logic              ec_bad;

  opf_ea_calc #(.WORD_W(WORD_W)) u_ea (
    .mode_i (mode_q),
    .a_i    (a_q),
    .rval_i (rval_q),
    .addr_o (ec_addr),
    .opnd_o (ec_opnd),
    .reads_o(ec_reads),
    .bad_o  (ec_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= '0;
      a_q       <= '0;
      rval_q    <= '0;
      ptr_phase <= 1'b0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      done      <= 1'b0;
      illegal   <= 1'b0;
      operand   <= '0;
      eff_addr  <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      mem_rd  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q <= mode_i;
            a_q    <= a_i;
            rval_q <= rval_i;
            state  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (ec_reads == 2'd0) begin
            done     <= 1'b1;
            illegal  <= ec_bad;
            operand  <= ec_opnd;
            eff_addr <= '0;
            state    <= ST_IDLE;
          end else begin
            mem_addr  <= ec_addr;
            eff_addr  <= ec_addr;
            mem_rd    <= 1'b1;
            ptr_phase <= (ec_reads == 2'd2);
            state     <= ST_RD;
          end
        end
        ST_RD: state <= ST_CAP;
        ST_CAP: begin
          if (ptr_phase) begin
            mem_addr  <= mem_rdata;
            eff_addr  <= mem_rdata;
            mem_rd    <= 1'b1;
            ptr_phase <= 1'b0;
            state     <= ST_RD;
          end else begin
            operand <= mem_rdata;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opnd_fetch_unit.sv
module opnd_fetch_unit
  import opf_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int REG_CNT = 8,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [WORD_W-1:0] fld_a,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic              rf_we,
  input  logic [IDX_W-1:0]  rf_waddr,
  input  logic [WORD_W-1:0] rf_wdata,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              illegal,
  output logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] eff_addr
);
  logic [WORD_W-1:0] rf_rval;

  opf_regfile #(.REG_CNT(REG_CNT), .WORD_W(WORD_W)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .waddr(rf_waddr),
    .wdata(rf_wdata),
    .raddr(reg_idx),
    .rdata(rf_rval)
  );

  opf_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mode_i   (mode),
    .a_i      (fld_a),
    .rval_i   (rf_rval),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_rdata(mem_rdata),
    .done     (done),
    .illegal  (illegal),
    .operand  (operand),
    .eff_addr (eff_addr)
  );
endmodule

// File: rtl/opf_checker.sv
module opf_checker
  import opf_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [MODE_W-1:0] mode,
  input logic [WORD_W-1:0] fld_a,
  input logic              mem_rd,
  input logic              done,
  input logic              illegal,
  input logic [WORD_W-1:0] operand,
  input logic [WORD_W-1:0] eff_addr
);
  logic              busy_c;
  logic              acc;
  logic [MODE_W-1:0] mode_c;
  logic [WORD_W-1:0] a_c;
  logic [1:0]        rd_cnt;

  assign acc = start && (!busy_c || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_c <= 1'b0;
      mode_c <= '0;
      a_c    <= '0;
      rd_cnt <= '0;
    end else begin
      if (acc) begin
        busy_c <= 1'b1;
        mode_c <= mode;
        a_c    <= fld_a;
        rd_cnt <= '0;
      end else begin
        if (done) busy_c <= 1'b0;
        if (mem_rd) rd_cnt <= rd_cnt + 2'd1;
      end
    end
  end

  a_r1_imm_operand: assert property (@(posedge clk) disable iff (rst)
    done && mode_c == AM_IMM |-> operand == a_c && eff_addr == '0 && !illegal);
  a_r4_no_read_modes: assert property (@(posedge clk) disable iff (rst)
    done && (mode_c == AM_IMM || mode_c == AM_REG) |-> rd_cnt == 2'd0);
  a_r2_single_read: assert property (@(posedge clk) disable iff (rst)
    done && (mode_c == AM_DIR || mode_c == AM_RIND || mode_c == AM_DISP) |-> rd_cnt == 2'd1);
  a_r3_two_reads: assert property (@(posedge clk) disable iff (rst)
    done && mode_c == AM_IND |-> rd_cnt == 2'd2);
  a_r8_illegal_result: assert property (@(posedge clk) disable iff (rst)
    done && mode_c > AM_DISP |-> illegal && operand == '0 && rd_cnt == 2'd0);
  a_r8_illegal_with_done: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  a_r10_no_read_at_done: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !done);
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_c |-> !mem_rd && !done);
endmodule

bind opnd_fetch_unit opf_checker #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .mode    (mode),
  .fld_a   (fld_a),
  .mem_rd  (mem_rd),
  .done    (done),
  .illegal (illegal),
  .operand (operand),
  .eff_addr(eff_addr)
);

// File: tb/tb_opnd_fetch_unit.sv
module tb_opnd_fetch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] fld_a = '0;
  logic [2:0]  reg_idx = '0;
  logic        rf_we = 1'b0;
  logic [2:0]  rf_waddr = '0;
  logic [15:0] rf_wdata = '0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [15:0] mem_rdata = '0;
  logic        done, illegal;
  logic [15:0] operand, eff_addr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  logic [15:0] mem [256];
  logic [15:0] shadow [8];

  // reference model state
  bit          m_busy = 0;
  int          m_cnt = 0;
  int          m_lat = 0;
  logic [15:0] m_a1, m_a2, m_opnd, m_ea;
  bit          m_ill;
  string       m_req;

  opnd_fetch_unit dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .fld_a(fld_a),
    .reg_idx(reg_idx), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .done(done), .illegal(illegal), .operand(operand), .eff_addr(eff_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0;
    end else begin
      if (m_busy && m_cnt == m_lat) m_busy = 0;
      if (start && !m_busy) begin
        logic [15:0] rv;
        rv = shadow[reg_idx];
        m_busy = 1; m_cnt = 0; m_ill = 0; m_a1 = '0; m_a2 = '0; m_ea = '0; m_opnd = '0;
        case (mode)
          3'd0: begin m_lat = 1; m_opnd = fld_a; m_req = "R1"; end
          3'd1: begin m_lat = 3; m_a1 = fld_a; m_ea = fld_a; m_opnd = mem[fld_a[7:0]]; m_req = "R2"; end
          3'd2: begin
            m_lat = 5; m_a1 = fld_a; m_a2 = mem[fld_a[7:0]]; m_ea = m_a2;
            m_opnd = mem[m_a2[7:0]]; m_req = "R3";
          end
          3'd3: begin m_lat = 1; m_opnd = rv; m_req = "R4"; end
          3'd4: begin m_lat = 3; m_a1 = rv; m_ea = rv; m_opnd = mem[rv[7:0]]; m_req = "R5"; end
          3'd5: begin
            m_lat = 3; m_a1 = fld_a + rv; m_ea = m_a1; m_opnd = mem[m_a1[7:0]]; m_req = "R6";
          end
          default: begin m_lat = 1; m_ill = 1; m_req = "R8"; end
        endcase
      end else if (m_busy) begin
        m_cnt++;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit exp_done, exp_rd;
      exp_done = m_busy && m_cnt == m_lat;
      exp_rd   = m_busy && (m_cnt == 1 || (m_lat == 5 && m_cnt == 3)) && m_lat > 1;
      chk("R7", "done", 16'(done), 16'(exp_done));
      chk("R10", "mem_rd", 16'(mem_rd), 16'(exp_rd));
      if (exp_rd) chk(m_req, "mem_addr", mem_addr, (m_cnt == 1) ? m_a1 : m_a2);
      if (exp_done) begin
        chk(m_req, "operand", operand, m_opnd);
        chk(m_req, "eff_addr", eff_addr, m_ea);
      end
      chk("R8", "illegal", 16'(illegal), 16'(exp_done && m_ill));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL R7 watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr_reg(input logic [2:0] idx, input logic [15:0] val);
    @(negedge clk);
    rf_we = 1; rf_waddr = idx; rf_wdata = val;
    shadow[idx] = val;
    @(negedge clk);
    rf_we = 0;
  endtask

  task automatic go(input logic [2:0] md, input logic [15:0] a, input logic [2:0] r);
    @(negedge clk);
    start = 1; mode = md; fld_a = a; reg_idx = r;
    @(negedge clk);
    start = 0;
    while (m_busy && !(m_cnt == m_lat)) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 40503 + 4660);
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7", "reset done", 16'(done), 16'h0);
    chk("R7", "reset mem_rd", 16'(mem_rd), 16'h0);
    chk("R8", "reset illegal", 16'(illegal), 16'h0);
    rst = 0;
    // R11: load register file
    for (int i = 0; i < 8; i++) wr_reg(3'(i), 16'(i * 16'h1111 + 16'h0203));
    wr_reg(3'd2, 16'hFFF0);
    go(3'd0, 16'hBEEF, 3'd0);  // R1
    go(3'd0, 16'h0000, 3'd5);  // R1
    go(3'd1, 16'h0042, 3'd0);  // R2
    go(3'd1, 16'hFF07, 3'd0);  // R2 high address
    go(3'd2, 16'h0011, 3'd0);  // R3
    go(3'd2, 16'h00C8, 3'd0);  // R3
    go(3'd3, 16'h0000, 3'd6);  // R4
    go(3'd3, 16'h1234, 3'd2);  // R4
    go(3'd4, 16'h0000, 3'd3);  // R5
    go(3'd5, 16'h0020, 3'd2);  // R6 wraps modulo 2^16
    go(3'd5, 16'h0100, 3'd1);  // R6
    go(3'd6, 16'h5555, 3'd1);  // R8
    go(3'd7, 16'hAAAA, 3'd7);  // R8
    // R9: stray starts during an indirect operation are ignored
    @(negedge clk);
    start = 1; mode = 3'd2; fld_a = 16'h0033; reg_idx = 3'd0;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    start = 1; mode = 3'd0; fld_a = 16'h7777;
    @(negedge clk);
    start = 1; mode = 3'd6;
    @(negedge clk);
    start = 0;
    while (m_busy && !(m_cnt == m_lat)) @(negedge clk);
    // start held through done: accepted in the cycle after done (R9, R7)
    start = 1; mode = 3'd1; fld_a = 16'h0077;
    @(negedge clk);
    start = 0;
    while (m_busy && !(m_cnt == m_lat)) @(negedge clk);
    // R11: overwrite a register, later operation sees it
    wr_reg(3'd6, 16'hC0DE);
    go(3'd3, 16'h0000, 3'd6);
    go(3'd4, 16'h0000, 3'd6);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule